// File: doc/BRIEF.md
# Four-Channel Chained Interval Timer

This block holds four identical 16-bit up-counting timer channels. Each channel either advances from a prescaled copy of the system clock or, in chained mode, counts the overflow pulses of the channel below it. Channel 0 takes its chain input from a pin of the block. Software writes a per-channel reload value and a per-channel control byte, and reads back any channel's integer count. A channel that passes 0xFFFF loads its reload value again, sends a one-cycle overflow pulse up the chain and, if enabled, raises a one-cycle interrupt request.

The reload value enters the counter only when the run bit goes from 0 to 1. Control byte layout: bits [1:0] select the clock divide (00 = 1, 01 = 64, 10 = 256, 11 = 1024 system clocks per count). Bit 2 selects chained mode. Bit 6 enables the interrupt. Bit 7 is the run bit. A control write takes effect at the following clock edge. The counting step at the edge that captures the write still uses the old control value.

Top module: `tmr_group`

## Requirements
- R1: With the run bit set and chained mode off, a channel loaded at clock edge E holds reload + floor(k / D) after edge E+k. D is 1, 64, 256 or 1024 for divide codes 00, 01, 10 and 11 in control bits [1:0].
- R2: A control write with bit 7 = 1 to a stopped channel loads the counter with the reload register at that edge. It also restarts the divide phase.
- R3: Rewriting control bit 7 = 1 on a running channel does not reload it. Counting goes on one step per tick.
- R4: A tick at count 0xFFFF loads the reload value and pulses that channel's ovf_out bit for exactly one cycle. Counting then continues from the reload value.
- R5: With bit 7 clear the count is frozen, whatever the clock or chain inputs do, and it stays readable.
- R6: With control bit 2 set, the divide code is ignored. The channel advances once per high cycle of its chain input, which is casc_in for channel 0 and ovf_out[i-1] for channel i.
- R7: irq_out[i] pulses together with ovf_out[i] only when control bit 6 was set at the overflow. Otherwise it stays low.
- R8: Writing the reload register of a running channel does not change its count until the next start or wrap.
- R9: After reset every count is 0 and every ovf_out and irq_out bit is 0.
- R10: rd_count shows the count of the channel chosen by rd_ch, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_ctrl | input | 1 | 1 writes the control byte, 0 writes the reload value |
| wr_data | input | 16 | Write data |
| rd_ch | input | 2 | Channel whose count appears on rd_count |
| rd_count | output | 16 | Count of channel rd_ch |
| casc_in | input | 1 | Chain input of channel 0, one count per high cycle |
| ovf_out | output | 4 | Per-channel one-cycle overflow pulses |
| irq_out | output | 4 | Per-channel one-cycle interrupt requests |

## Verification
The properties assume that the chain input is a synchronous level sampled once per cycle, and that only one register of one channel is written in a cycle. This is why a reload value is stable across the edge where a start loads it. The bench drives every input, casc_in included, at the falling edge. It holds each write strobe for exactly one rising edge and pulses casc_in for single cycles only. Chained tests run with the lower channel at divide-by-one, so overflow pulses arrive as fast as the design can produce them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_RUN_BIT  = 7;
    localparam int CTRL_IRQ_BIT  = 6;
    localparam int CTRL_CHAIN_BIT = 2;

    localparam int SHIFT_SEL0 = 0;
    localparam int SHIFT_SEL1 = 6;
    localparam int SHIFT_SEL2 = 8;
    localparam int SHIFT_SEL3 = 10;

    typedef struct packed {
        logic       run;
        logic       irq_en;
        logic       chain;
        logic [1:0] div_sel;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t unpack_ctrl(input logic [7:0] b);
        tmr_ctrl_t c;
        c.run     = b[CTRL_RUN_BIT];
        c.irq_en  = b[CTRL_IRQ_BIT];
        c.chain   = b[CTRL_CHAIN_BIT];
        c.div_sel = b[1:0];
        return c;
    endfunction

    function automatic int div_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return SHIFT_SEL0;
            2'd1:    return SHIFT_SEL1;
            2'd2:    return SHIFT_SEL2;
            default: return SHIFT_SEL3;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PHASE_W-1:0] phase_d, phase_q;
    logic [PHASE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PHASE_W; i++) begin
            mask[i] = (i < div_shift(sel));
        end
        tick    = ((phase_q & mask) == mask);
        phase_d = clear ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R1: a tick of a divided clock leaves the low phase bits at zero, so no tick follows at once
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'b00 && !clear) |=> (!tick || sel == 2'b00));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PHASE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reload,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             casc_in,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             irq;
    } chan_st_t;

    chan_st_t  st_d, st_q;
    tmr_ctrl_t new_ctrl;
    logic      run_rise;
    logic      pre_tick;
    logic      step;

    tmr_prescale #(.PHASE_W(PHASE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (run_rise),
        .sel   (st_q.ctrl.div_sel),
        .tick  (pre_tick)
    );

    always_comb begin
        new_ctrl = unpack_ctrl(wr_data[7:0]);
        run_rise = wr_ctrl && new_ctrl.run && !st_q.ctrl.run;
        step     = st_q.ctrl.run && (st_q.ctrl.chain ? casc_in : pre_tick);

        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.irq = 1'b0;

        if (step) begin
            if (st_q.count == {CNT_W{1'b1}}) begin
                st_d.count = st_q.reload;
                st_d.ovf   = 1'b1;
                st_d.irq   = st_q.ctrl.irq_en;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end

        if (wr_reload) st_d.reload = wr_data;
        if (wr_ctrl)   st_d.ctrl   = new_ctrl;
        if (run_rise)  st_d.count  = st_q.reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;
    assign irq_o   = st_q.irq;

    // R2: a start loads the reload value held before the edge
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctrl.run) |-> st_q.count == $past(st_q.reload));

    // R3: a running channel moves by at most one between edges when it does not wrap
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ctrl.run) && st_q.ctrl.run && !st_q.ovf) |->
        (st_q.count == $past(st_q.count) || st_q.count == $past(st_q.count) + 1'b1));

    // R4: an overflow comes from 0xFFFF and lands on the reload value
    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> (st_q.count == $past(st_q.reload) && $past(st_q.count) == {CNT_W{1'b1}}));

    // R5: a stopped channel keeps its count
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.ctrl.run) && !st_q.ctrl.run) |-> $stable(st_q.count));

    // R6: in chained mode nothing but the chain input moves the count
    a_r6_chain_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.ctrl.chain) && $past(st_q.ctrl.run) && !$past(casc_in) && st_q.ctrl.run)
        |-> $stable(st_q.count));

    // R7: a request needs an overflow and the enable bit
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.ovf && $past(st_q.ctrl.irq_en)));

endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int CNT_W   = 16,
    parameter int PHASE_W = 10,
    localparam int SEL_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_ch,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_ch,
    output logic [CNT_W-1:0] rd_count,
    input  logic             casc_in,
    output logic [N_CH-1:0]  ovf_out,
    output logic [N_CH-1:0]  irq_out
);

    logic [CNT_W-1:0] counts [N_CH];
    logic [N_CH-1:0]  chain_in;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        if (i == 0) begin : g_first
            assign chain_in[i] = casc_in;
        end else begin : g_next
            assign chain_in[i] = ovf_out[i-1];
        end

        tmr_channel #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_reload (wr_en && !wr_ctrl && (wr_ch == SEL_W'(i))),
            .wr_ctrl   (wr_en &&  wr_ctrl && (wr_ch == SEL_W'(i))),
            .wr_data   (wr_data),
            .casc_in   (chain_in[i]),
            .count_o   (counts[i]),
            .ovf_o     (ovf_out[i]),
            .irq_o     (irq_out[i])
        );
    end

    assign rd_count = counts[rd_ch];

    // R7: every request lines up with its own channel's overflow
    a_r7_irq_within_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~ovf_out) == '0);

endmodule

// File: tb/sim_tmr_group.sv
module sim_tmr_group;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic        wr_ctrl = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_ch = '0;
    logic [15:0] rd_count;
    logic        casc_in = 1'b0;
    logic [3:0]  ovf_out;
    logic [3:0]  irq_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tmr_group u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_count(rd_count), .casc_in(casc_in),
        .ovf_out(ovf_out), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] rl;
        logic [15:0] wt;
        logic [15:0] expv;
    } vec_t;

    // R1 and R4 vectors: divide code, reload, edges after the start, expected count
    localparam vec_t VEC [6] = '{
        '{2'd0, 16'h1000, 16'd10,   16'h100A},
        '{2'd1, 16'h0200, 16'd200,  16'h0203},
        '{2'd2, 16'h0010, 16'd600,  16'h0012},
        '{2'd3, 16'h0000, 16'd2100, 16'h0002},
        '{2'd0, 16'hFFF0, 16'd20,   16'hFFF4},
        '{2'd1, 16'hFFFF, 16'd130,  16'hFFFF}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic is_ctrl, input logic [15:0] d);
        wr_en = 1'b1; wr_ch = ch; wr_ctrl = is_ctrl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, output logic [15:0] v);
        rd_ch = ch;
        #1;
        v = rd_count;
    endtask

    task automatic pulse_casc();
        casc_in = 1'b1;
        @(negedge clk);
        casc_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        for (int c = 0; c < 4; c++) begin
            rd(2'(c), v);
            chk("R9 count after reset", v, 16'h0000);
        end
        chk("R9 ovf after reset", {12'h0, ovf_out}, 16'h0);
        chk("R9 irq after reset", {12'h0, irq_out}, 16'h0);

        // R10 / R5: start then stop channels 1..3; the stop edge still counts once
        wr(2'd1, 1'b0, 16'h1234); wr(2'd1, 1'b1, 16'h0080); wr(2'd1, 1'b1, 16'h0000);
        wr(2'd2, 1'b0, 16'h2222); wr(2'd2, 1'b1, 16'h0080); wr(2'd2, 1'b1, 16'h0000);
        wr(2'd3, 1'b0, 16'h3333); wr(2'd3, 1'b1, 16'h0080); wr(2'd3, 1'b1, 16'h0000);
        repeat (50) @(negedge clk);
        rd(2'd1, v); chk("R10 R5 channel 1", v, 16'h1235);
        rd(2'd2, v); chk("R10 R5 channel 2", v, 16'h2223);
        rd(2'd3, v); chk("R10 R5 channel 3", v, 16'h3334);

        // R1 / R4 vector table on channel 0
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, 1'b1, 16'h0000);
            wr(2'd0, 1'b0, VEC[i].rl);
            wr(2'd0, 1'b1, 16'h0080 | {14'h0, VEC[i].sel});
            repeat (int'(VEC[i].wt)) @(negedge clk);
            rd(2'd0, v);
            chk($sformatf("R1 R4 vector %0d", i), v, VEC[i].expv);
        end

        // R3 rewrite while running, R8 reload write while running
        wr(2'd0, 1'b1, 16'h0000);
        wr(2'd0, 1'b0, 16'h0100);
        wr(2'd0, 1'b1, 16'h0080);
        wr(2'd0, 1'b1, 16'h0080);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R3 no reload on rewrite", v, 16'h0106);
        wr(2'd0, 1'b0, 16'h5555);
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R8 reload write while running", v, 16'h010A);

        // R4 / R7 overflow with the interrupt enabled
        wr(2'd0, 1'b1, 16'h0000);
        wr(2'd0, 1'b0, 16'hFFFE);
        wr(2'd0, 1'b1, 16'h00C0);
        @(negedge clk);
        rd(2'd0, v); chk("R4 count before wrap", v, 16'hFFFF);
        chk("R4 no ovf before wrap", {15'h0, ovf_out[0]}, 16'h0);
        @(negedge clk);
        rd(2'd0, v); chk("R4 reload at wrap", v, 16'hFFFE);
        chk("R4 ovf pulse", {15'h0, ovf_out[0]}, 16'h1);
        chk("R7 irq pulse enabled", {15'h0, irq_out[0]}, 16'h1);
        @(negedge clk);
        chk("R4 ovf one cycle", {15'h0, ovf_out[0]}, 16'h0);
        chk("R7 irq one cycle", {15'h0, irq_out[0]}, 16'h0);

        // R7 overflow with the interrupt disabled
        wr(2'd0, 1'b1, 16'h0000);
        wr(2'd0, 1'b1, 16'h0080);
        @(negedge clk);
        @(negedge clk);
        chk("R7 ovf with irq off", {15'h0, ovf_out[0]}, 16'h1);
        chk("R7 no irq when disabled", {15'h0, irq_out[0]}, 16'h0);

        // R6 channel 1 chained to channel 0, divide code 11 ignored
        wr(2'd0, 1'b1, 16'h0000);
        wr(2'd0, 1'b0, 16'hFFFE);
        wr(2'd1, 1'b0, 16'h0010);
        wr(2'd1, 1'b1, 16'h0087);
        wr(2'd0, 1'b1, 16'h0080);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R6 chained count", v, 16'h0019);

        // R6 channel 0 chained to casc_in
        wr(2'd0, 1'b1, 16'h0000);
        wr(2'd0, 1'b0, 16'h0020);
        wr(2'd0, 1'b1, 16'h0084);
        pulse_casc(); pulse_casc(); pulse_casc();
        repeat (100) @(negedge clk);
        rd(2'd0, v); chk("R6 external chain pulses", v, 16'h0023);

        // R5 chain pulses ignored while stopped
        wr(2'd0, 1'b1, 16'h0004);
        pulse_casc(); pulse_casc();
        rd(2'd0, v); chk("R5 stopped ignores chain", v, 16'h0023);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule